// File: doc/BRIEF.md
# Task-Sequence Signature Checker

This block watches a processor run its software tasks and confirms that they run in the right order and the right number of times. Each task invocation sends one pulse on `step`. Each pulse rotates a preloaded 16-bit data word by one position and feeds the bit that falls out into a 16-bit signature register. The periodic timer interrupt can also pulse `tick`, which advances the signature once with a zero input bit. In this way the timer rate and the ratio of ticks to tasks become part of the signature.

Software pulses `start` to pick one of five seed/word sets and to set how many task cycles make up one check window. At the end of each task cycle it pulses `check`. On the last `check` of a window, the block compares the signature with a table entry for that set and window length. The table is computed when the design is elaborated. A match pulses `kick` toward a simple external watchdog. A mismatch raises a sticky `fail`, and no further kick is issued after that. After every comparison the block reloads itself from the next set, so successive windows use different seeds and words.

The table assumes that each task cycle consists of `STEPS_PER_CYC` steps followed by `TICKS_PER_CYC` ticks. A tick may share a clock with the last step of the cycle, because inside one clock the step is always applied before the tick. All pins are plain control strobes and status levels. There is no streamed data and there is no back-pressure.

Top module: `task_sig_checker`

## Requirements
- R1: After reset, `fail` and `kick` are 0 and the block is idle. A reset is the only way to clear `fail`.
- R2: A `start` pulse with `start_sel` in 0..4 arms the block and loads that set. The set's seed goes into the signature and its word into the data register, and `cyc_cfg` is latched, giving a window of `cyc_cfg`+1 task cycles. The seeds for sets 0..4 are 16'hACE1, 16'h1D0F, 16'h7E55, 16'hC3A9 and 16'h5B24. The words for sets 0..4 are 16'h9A3C, 16'h0F5A, 16'hE817, 16'h36C1 and 16'hB4D2. A `start` with `start_sel` of 5..7 is ignored.
- R3: Each `step` shifts the signature once. The input bit is bit 0 of the data word. The new signature is {sig[14:0],0}, XORed with 16'h1021 when sig[15] XOR the input bit is 1. The data word then rotates right by one position.
- R4: Each `tick` shifts the signature once with input bit 0. When `step` and `tick` arrive in the same clock, the step shift is applied first and the tick shift second.
- R5: While armed, each `check` ends one task cycle. Only the (`cyc_cfg`+1)-th `check` of a window compares the signature. The signature is compared with the expected value for the current set and that window length, taken as it stood before that clock. `step` and `tick` in that same clock are discarded by the reload that follows.
- R6: A matching comparison while `fail` is 0 drives `kick` high for exactly one clock, in the clock after the one in which `check` was sampled.
- R7: A mismatching comparison sets `fail`. From then on `kick` stays low until reset, even for matching windows.
- R8: After every comparison the set index advances by one, wrapping from 4 to 0. The new set's seed and word are loaded, and the window length is kept. A new `start` overrides the current set and window at any time.
- R9: Before the first accepted `start`, `check`, `step` and `tick` have no effect: `kick` and `fail` stay 0.
- R10: The expected value for a set and a window of n cycles is the signature reached from that set's seed and word after n repetitions of `STEPS_PER_CYC` steps followed by `TICKS_PER_CYC` ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arm and load the selected set |
| start_sel | input | 3 | Set index for `start` (0..4 valid) |
| cyc_cfg | input | 2 | Task cycles per window minus one, latched on `start` |
| step | input | 1 | One pulse per task invocation |
| tick | input | 1 | One pulse per timer interrupt |
| check | input | 1 | End-of-task-cycle strobe |
| kick | output | 1 | One-clock watchdog service pulse on a match |
| fail | output | 1 | Sticky mismatch flag |

## Verification
A `step` or `tick` changes the signature at the clock edge that samples it. A `check` that completes a window produces its `kick` or `fail` one clock later, at the output of a register. The bench drives every strobe on the falling edge, lets one rising edge pass, and samples `kick` and `fail` on the next falling edge. At that point the result of that very `check` is visible, and a kick from an earlier window has already dropped. The expected signatures come from a bench model that repeats each shift as it is driven, so wrong stimulus orders and counts predict their own outcome.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int SIG_W = 16;
  localparam logic [SIG_W-1:0] POLY = 16'h1021;

  typedef logic [SIG_W-1:0] sig_t;

  // one signature shift with a serial input bit
  function automatic sig_t sig_shift(sig_t s, logic b);
    logic fb;
    fb = s[SIG_W-1] ^ b;
    return {s[SIG_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  function automatic sig_t rot_right(sig_t d);
    return {d[0], d[SIG_W-1:1]};
  endfunction

  function automatic sig_t seed_of(int i);
    case (i)
      0: return 16'hACE1;
      1: return 16'h1D0F;
      2: return 16'h7E55;
      3: return 16'hC3A9;
      default: return 16'h5B24;
    endcase
  endfunction

  function automatic sig_t word_of(int i);
    case (i)
      0: return 16'h9A3C;
      1: return 16'h0F5A;
      2: return 16'hE817;
      3: return 16'h36C1;
      default: return 16'hB4D2;
    endcase
  endfunction

  // signature after ncyc canonical task cycles (steps, then ticks)
  function automatic sig_t expect_sig(int set, int ncyc, int steps, int ticks);
    sig_t s;
    sig_t d;
    s = seed_of(set);
    d = word_of(set);
    for (int c = 0; c < ncyc; c++) begin
      for (int k = 0; k < steps; k++) begin
        s = sig_shift(s, d[0]);
        d = rot_right(d);
      end
      for (int k = 0; k < ticks; k++) s = sig_shift(s, 1'b0);
    end
    return s;
  endfunction
endpackage

// File: rtl/tsc_sig_reg.sv
module tsc_sig_reg
  import tsc_pkg::*;
#(
  parameter int SET_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SET_W-1:0] load_set,
  input  logic             en,
  input  logic             step,
  input  logic             tick,
  output sig_t             sig
);
  sig_t word;
  sig_t after_step;
  sig_t after_tick;

  always_comb begin
    after_step = step ? sig_shift(sig, word[0]) : sig;
    after_tick = tick ? sig_shift(after_step, 1'b0) : after_step;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig  <= '0;
      word <= '0;
    end else if (load) begin
      sig  <= seed_of(int'(load_set));
      word <= word_of(int'(load_set));
    end else if (en) begin
      sig <= after_tick;
      if (step) word <= rot_right(word);
    end
  end
endmodule

// File: rtl/tsc_expect_rom.sv
module tsc_expect_rom
  import tsc_pkg::*;
#(
  parameter int N_SETS  = 5,
  parameter int MAX_CYC = 4,
  parameter int STEPS   = 3,
  parameter int TICKS   = 1,
  parameter int SET_W   = 3,
  parameter int CYC_W   = 2
) (
  input  logic [SET_W-1:0] set,
  input  logic [CYC_W-1:0] cyc_lim,
  output sig_t             exp_sig
);
  sig_t tab [N_SETS][MAX_CYC];

  for (genvar gs = 0; gs < N_SETS; gs++) begin : g_set
    for (genvar gc = 0; gc < MAX_CYC; gc++) begin : g_cyc
      assign tab[gs][gc] = expect_sig(gs, gc + 1, STEPS, TICKS);
    end
  end

  always_comb begin
    exp_sig = '0;
    for (int s = 0; s < N_SETS; s++)
      for (int c = 0; c < MAX_CYC; c++)
        if (int'(set) == s && int'(cyc_lim) == c) exp_sig = tab[s][c];
  end
endmodule

// File: rtl/tsc_sequencer.sv
module tsc_sequencer
  import tsc_pkg::*;
#(
  parameter int N_SETS = 5,
  parameter int SET_W  = 3,
  parameter int CYC_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SET_W-1:0] start_sel,
  input  logic [CYC_W-1:0] cyc_cfg,
  input  logic             check,
  input  sig_t             sig,
  input  sig_t             exp_sig,
  output logic             armed,
  output logic [SET_W-1:0] set_idx,
  output logic [CYC_W-1:0] cyc_lim,
  output logic             load,
  output logic [SET_W-1:0] load_set,
  output logic             kick,
  output logic             fail
);
  logic [CYC_W-1:0] cyc_cnt;
  logic             do_start;
  logic             window_end;
  logic [SET_W-1:0] next_set;

  always_comb begin
    do_start   = start && (32'(start_sel) < N_SETS);
    window_end = armed && check && (cyc_cnt == cyc_lim);
    next_set   = (set_idx == SET_W'(N_SETS - 1)) ? '0 : set_idx + 1'b1;
    load       = do_start || window_end;
    load_set   = do_start ? start_sel : next_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      set_idx <= '0;
      cyc_cnt <= '0;
      cyc_lim <= '0;
      kick    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      kick <= 1'b0;
      if (do_start) begin
        armed   <= 1'b1;
        set_idx <= start_sel;
        cyc_cnt <= '0;
        cyc_lim <= cyc_cfg;
      end else if (window_end) begin
        if (sig == exp_sig) kick <= !fail;
        else                fail <= 1'b1;
        set_idx <= next_set;
        cyc_cnt <= '0;
      end else if (armed && check) begin
        cyc_cnt <= cyc_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/task_sig_checker.sv
module task_sig_checker
  import tsc_pkg::*;
#(
  parameter int N_SETS        = 5,
  parameter int MAX_CYC       = 4,
  parameter int STEPS_PER_CYC = 3,
  parameter int TICKS_PER_CYC = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] start_sel,
  input  logic [1:0] cyc_cfg,
  input  logic       step,
  input  logic       tick,
  input  logic       check,
  output logic       kick,
  output logic       fail
);
  localparam int SET_W = 3;
  localparam int CYC_W = $clog2(MAX_CYC);

  sig_t             sig;
  sig_t             exp_sig;
  logic             armed;
  logic             load;
  logic [SET_W-1:0] load_set;
  logic [SET_W-1:0] set_idx;
  logic [CYC_W-1:0] cyc_lim;

  tsc_sequencer #(.N_SETS(N_SETS), .SET_W(SET_W), .CYC_W(CYC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_sel(start_sel),
    .cyc_cfg(cyc_cfg), .check(check), .sig(sig), .exp_sig(exp_sig),
    .armed(armed), .set_idx(set_idx), .cyc_lim(cyc_lim), .load(load),
    .load_set(load_set), .kick(kick), .fail(fail)
  );

  tsc_sig_reg #(.SET_W(SET_W)) u_sig (
    .clk(clk), .rst_n(rst_n), .load(load), .load_set(load_set),
    .en(armed), .step(step), .tick(tick), .sig(sig)
  );

  tsc_expect_rom #(
    .N_SETS(N_SETS), .MAX_CYC(MAX_CYC), .STEPS(STEPS_PER_CYC),
    .TICKS(TICKS_PER_CYC), .SET_W(SET_W), .CYC_W(CYC_W)
  ) u_rom (
    .set(set_idx), .cyc_lim(cyc_lim), .exp_sig(exp_sig)
  );
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int N_SETS = 5,
  parameter int SET_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             check,
  input logic             armed,
  input logic [SET_W-1:0] set_idx,
  input logic             kick,
  input logic             fail
);
  // R7: fail never drops without reset
  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail);

  // R7: no kick while failed
  p_kick_needs_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> !fail);

  // R6: kick follows a sampled check
  p_kick_after_check_r6: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> $past(check));

  // R9: idle block produces no result
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (!kick && !$rose(fail)));

  // R8: set index stays inside the table
  p_set_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(set_idx) < N_SETS);
endmodule

bind task_sig_checker tsc_checker #(.N_SETS(N_SETS), .SET_W(SET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .check(check), .armed(armed),
  .set_idx(set_idx), .kick(kick), .fail(fail)
);

// File: tb/sim_task_sig_checker.sv
module sim_task_sig_checker;
  localparam int STEPS = 3;
  localparam int TICKS = 1;

  logic       clk = 0, rst_n = 0, start = 0, step = 0, tick = 0, check = 0;
  logic [2:0] sel = 0;
  logic [1:0] cfg = 0;
  wire        kick, fail;
  int total = 0, bad = 0;

  logic [15:0] ms, md;
  int  mset = 0, mcnt = 0, mlim = 0;
  bit  marmed = 0, mfail = 0;

  task_sig_checker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_sel(sel), .cyc_cfg(cfg),
    .step(step), .tick(tick), .check(check), .kick(kick), .fail(fail)
  );

  always #2 clk = ~clk;

  function automatic logic [15:0] sh(logic [15:0] s, logic b);
    return {s[14:0], 1'b0} ^ ((s[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction
  function automatic logic [15:0] seedv(int i);
    logic [15:0] t [5] = '{16'hACE1, 16'h1D0F, 16'h7E55, 16'hC3A9, 16'h5B24};
    return t[i];
  endfunction
  function automatic logic [15:0] wordv(int i);
    logic [15:0] t [5] = '{16'h9A3C, 16'h0F5A, 16'hE817, 16'h36C1, 16'hB4D2};
    return t[i];
  endfunction
  function automatic logic [15:0] expv(int set, int n);
    logic [15:0] s, d;
    s = seedv(set);
    d = wordv(set);
    for (int c = 0; c < n; c++) begin
      for (int k = 0; k < STEPS; k++) begin
        s = sh(s, d[0]);
        d = {d[0], d[15:1]};
      end
      for (int k = 0; k < TICKS; k++) s = sh(s, 1'b0);
    end
    return s;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic clk1();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) clk1();
    rst_n = 1;
    marmed = 0;
    mfail  = 0;
  endtask

  task automatic do_start(int s, int c);
    start = 1; sel = 3'(s); cfg = 2'(c);
    clk1();
    start = 0;
    if (s < 5) begin
      marmed = 1; mset = s; mcnt = 0; mlim = c;
      ms = seedv(s); md = wordv(s);
    end
  endtask

  task automatic do_step(bit with_tick);
    step = 1; tick = with_tick;
    clk1();
    step = 0; tick = 0;
    if (marmed) begin
      ms = sh(ms, md[0]);
      md = {md[0], md[15:1]};
      if (with_tick) ms = sh(ms, 1'b0);
    end
  endtask

  task automatic do_tick();
    tick = 1;
    clk1();
    tick = 0;
    if (marmed) ms = sh(ms, 1'b0);
  endtask

  task automatic do_check(string req);
    bit ek = 0;
    check = 1;
    clk1();
    check = 0;
    if (marmed) begin
      if (mcnt == mlim) begin
        if (ms == expv(mset, mlim + 1)) ek = !mfail;
        else mfail = 1;
        mset = (mset + 1) % 5;
        ms = seedv(mset); md = wordv(mset); mcnt = 0;
      end else mcnt++;
    end
    chk({req, " kick"}, int'(kick), int'(ek));
    chk({req, " fail"}, int'(fail), int'(mfail));
  endtask

  // one well-formed task cycle; tick either joins the last step or follows it
  task automatic good_cycle(bit joined);
    for (int k = 0; k < STEPS; k++) do_step(joined && k == STEPS - 1);
    if (!joined) do_tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5EED));
    @(negedge clk);
    do_reset();
    chk("R1 reset kick", int'(kick), 0);
    chk("R1 reset fail", int'(fail), 0);

    // R9: activity before any start is ignored
    good_cycle(0);
    do_check("R9");

    // R2: out-of-range selection does not arm
    do_start(5, 0);
    good_cycle(0);
    do_check("R2 bad sel");

    // R3 R4 R5 R6: single-cycle window, tick separate and joined
    do_start(0, 0);
    good_cycle(0);
    do_check("R6 set0");
    good_cycle(1);
    do_check("R4 joined tick");

    // R8: wrap 4 -> 0 without a new start, two-cycle windows
    do_start(4, 1);
    good_cycle(0); do_check("R5 mid");
    good_cycle(1); do_check("R5 end set4");
    good_cycle(0); do_check("R8 mid");
    good_cycle(0); do_check("R8 wrapped set0");

    // R5: longest window
    do_start(3, 3);
    for (int c = 0; c < 4; c++) begin
      good_cycle(c[0]);
      do_check("R5 four cycles");
    end

    // R10 R3: random good traffic
    for (int it = 0; it < 60; it++) begin
      do_start(int'($urandom % 5), int'($urandom % 4));
      for (int w = 0; w < 1 + int'($urandom % 3); w++) begin
        for (int c = 0; c <= mlim; c++) begin
          good_cycle(1'($urandom % 2));
          repeat ($urandom % 3) clk1();
          do_check("R10 random");
        end
      end
    end

    // R7: missing tick gives mismatch, later good window gets no kick
    do_start(2, 0);
    for (int k = 0; k < STEPS; k++) do_step(0);
    do_check("R7 missing tick");
    chk("R7 fail set", int'(fail), 1);
    good_cycle(0);
    do_check("R7 kick withheld");

    // R1: reset clears fail
    do_reset();
    chk("R1 fail cleared", int'(fail), 0);

    // R4: tick ahead of steps is a different order
    do_start(1, 0);
    do_tick();
    for (int k = 0; k < STEPS; k++) do_step(0);
    do_check("R4 order");

    // R3: an extra step is caught
    do_reset();
    do_start(3, 0);
    good_cycle(0);
    do_step(0);
    do_check("R3 extra step");

    finish_up();
  end
endmodule